// File: doc/BRIEF.md
# Training Ordered-Set Disable/Loopback Request Detector

This block sits beside the link training state machine of a multi-lane serial link. For each lane, the receive path reports every ordered set it finishes decoding. It also says whether the set was a TS1, which link and lane numbers the set carried, and the state of its Disable Link and Loopback control bits. A per-lane input says whether the local transmitter is currently sending TS1s on that lane. From these, the block decides when the state machine must leave for the Disabled state or the Loopback state, and it signals each decision as a one-cycle request.

The two requests follow different rules. Disabled is requested as soon as any transmitting lane has received two TS1s in a row with Disable Link set. Loopback is requested only when every lane that is both transmitting and receiving TS1s has received two TS1s in a row with Loopback set. An optional number check can be switched on. When it is on, a TS1 only counts if its link number equals the assigned link number and its lane number equals the value expected for the current training phase: either the PAD code, or the lane number the root complex assigned to that lane.

All inputs are sampled on the rising clock edge. A request appears in the cycle after the edge that made its condition true.

Top module: `ts1_ctl_detector`

## Requirements
- R1: Once any lane whose transmit-TS1 flag is set has received two consecutive TS1s with the Disable Link bit set, `go_disabled` pulses high in the cycle after the edge that captured the second such TS1.
- R2: A lane whose transmit-TS1 flag is clear cannot cause either request. If such a lane already holds a completed streak when its flag is set, the corresponding request is raised in the cycle after the edge that samples the flag set.
- R3: `go_loopback` pulses once every lane that is both transmitting TS1s and receiving TS1s has received two consecutive TS1s with the Loopback bit set. A lane counts as receiving TS1s while the last ordered set it reported was a TS1.
- R4: When no lane is both transmitting and receiving TS1s, `go_loopback` stays low.
- R5: With `num_chk_en` at 0, the received link and lane numbers have no effect on whether a TS1 counts.
- R6: With `num_chk_en` at 1, a TS1 counts only if its link number equals `exp_link`.
- R7: With `num_chk_en` at 1, the lane number must also match the expected value. When `lane_mode` is 0 (width-start phase), the expected value is the PAD code 8'hF7. When `lane_mode` is 1 (recovery-idle phase), it is that lane's slice of `exp_lane` (lane i in bits 8i+7:8i).
- R8: A streak is broken by any reported ordered set that does not count: a TS1 with the relevant bit clear, a TS1 that fails the number check, or a non-TS1 set (`os_vld` high, `os_is_ts1` low). Cycles with `os_vld` low leave every streak unchanged.
- R9: Each request is a single-cycle pulse. A request fires again only after its condition has gone false and then become true again.
- R10: If the Disabled and Loopback conditions become true on the same edge, only `go_disabled` pulses. A Loopback condition that was masked in this way does not fire later while it stays true.
- R11: A cycle with `clr` high clears every streak and every receiving flag. Both requests are low in the cycle after that edge.
- R12: While `rst_n` is low, and in the first cycle after reset, both requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of all streak state |
| num_chk_en | input | 1 | 1 = enforce the link/lane number match |
| lane_mode | input | 1 | Expected lane number: 0 = PAD code, 1 = assigned lane number |
| exp_link | input | 8 | Assigned link number |
| exp_lane | input | LANES*8 | Assigned lane number per lane, lane i in bits 8i+7:8i |
| tx_ts1 | input | LANES | Lane is transmitting TS1s |
| os_vld | input | LANES | An ordered set was decoded on the lane this cycle |
| os_is_ts1 | input | LANES | The decoded ordered set is a TS1 |
| rx_link | input | LANES*8 | Received link number per lane |
| rx_lane | input | LANES*8 | Received lane number per lane |
| rx_dis_bit | input | LANES | Received Disable Link control bit |
| rx_lpb_bit | input | LANES | Received Loopback control bit |
| go_disabled | output | 1 | One-cycle request to enter Disabled |
| go_loopback | output | 1 | One-cycle request to enter Loopback |

## Verification
A lane counter stuck at or short of the target shows up at the ports on the first edge where a second qualifying TS1 arrives: the request either appears one TS1 early or fails to appear. A receiving flag or transmit sample that is wrong changes which lanes join the all-lanes Loopback vote. This is exposed by sequences in which one lane finishes its streak before another, or in which lanes stop receiving. An edge detector that keeps stale state shows up as a missing or repeated pulse in the cycle right after a condition rises. The stimulus therefore walks each streak through the hold, break and complete cases and samples the requests every cycle.

// File: rtl/ts1det_pkg.sv
package ts1det_pkg;

   localparam int unsigned SYM_W    = 8;
   localparam logic [7:0]  PAD_CODE = 8'hF7;

   typedef enum logic {
      LN_EXPECT_PAD      = 1'b0,
      LN_EXPECT_ASSIGNED = 1'b1
   } lane_mode_e;

endpackage

// File: rtl/ts1det_num_check.sv
module ts1det_num_check
   import ts1det_pkg::*;
#(
   parameter int unsigned NUM_W      = 8,
   parameter bit          CHECK_IMPL = 1'b1
) (
   input  logic             chk_en,
   input  lane_mode_e       mode,
   input  logic [NUM_W-1:0] exp_link,
   input  logic [NUM_W-1:0] exp_lane,
   input  logic [NUM_W-1:0] rx_link,
   input  logic [NUM_W-1:0] rx_lane,
   output logic             num_ok
);

   generate
      if (CHECK_IMPL) begin : g_cmp
         logic [NUM_W-1:0] want_lane;
         logic             link_eq;
         logic             lane_eq;

         always_comb begin
            want_lane = (mode == LN_EXPECT_ASSIGNED) ? exp_lane : NUM_W'(PAD_CODE);
            link_eq   = (rx_link == exp_link);
            lane_eq   = (rx_lane == want_lane);
            num_ok    = !chk_en || (link_eq && lane_eq);
         end
      end else begin : g_nocmp
         logic unused_in;
         assign unused_in = ^{chk_en, mode, exp_link, exp_lane, rx_link, rx_lane};
         assign num_ok    = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/ts1det_streak.sv
module ts1det_streak #(
   parameter int unsigned TARGET = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic os_vld,
   input  logic qual,
   output logic hit
);

   localparam int unsigned CW = (TARGET < 1) ? 1 : $clog2(TARGET + 1);
   localparam logic [CW-1:0] TOP = CW'(TARGET);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (os_vld) begin
         if (!qual) begin
            cnt_q <= '0;
         end else if (cnt_q != TOP) begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   assign hit = (cnt_q == TOP);

endmodule

// File: rtl/ts1det_lane.sv
module ts1det_lane
   import ts1det_pkg::*;
#(
   parameter int unsigned NUM_W      = 8,
   parameter int unsigned TARGET     = 2,
   parameter bit          CHECK_IMPL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             chk_en,
   input  lane_mode_e       mode,
   input  logic [NUM_W-1:0] exp_link,
   input  logic [NUM_W-1:0] exp_lane,
   input  logic             os_vld,
   input  logic             os_is_ts1,
   input  logic [NUM_W-1:0] rx_link,
   input  logic [NUM_W-1:0] rx_lane,
   input  logic             rx_dis,
   input  logic             rx_lpb,
   output logic             dis_hit,
   output logic             lpb_hit,
   output logic             rcv_ts1
);

   logic num_ok;
   logic qual_dis;
   logic qual_lpb;
   logic rcv_q;

   ts1det_num_check #(
      .NUM_W      (NUM_W),
      .CHECK_IMPL (CHECK_IMPL)
   ) u_num (
      .chk_en   (chk_en),
      .mode     (mode),
      .exp_link (exp_link),
      .exp_lane (exp_lane),
      .rx_link  (rx_link),
      .rx_lane  (rx_lane),
      .num_ok   (num_ok)
   );

   assign qual_dis = os_is_ts1 && rx_dis && num_ok;
   assign qual_lpb = os_is_ts1 && rx_lpb && num_ok;

   ts1det_streak #(.TARGET(TARGET)) u_dis (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .os_vld (os_vld),
      .qual   (qual_dis),
      .hit    (dis_hit)
   );

   ts1det_streak #(.TARGET(TARGET)) u_lpb (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .os_vld (os_vld),
      .qual   (qual_lpb),
      .hit    (lpb_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rcv_q <= 1'b0;
      end else if (clr) begin
         rcv_q <= 1'b0;
      end else if (os_vld) begin
         rcv_q <= os_is_ts1;
      end
   end

   assign rcv_ts1 = rcv_q;

endmodule

// File: rtl/ts1det_decide.sv
module ts1det_decide #(
   parameter int unsigned LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [LANES-1:0] tx_ts1,
   input  logic [LANES-1:0] rcv_ts1,
   input  logic [LANES-1:0] dis_hit,
   input  logic [LANES-1:0] lpb_hit,
   output logic             go_disabled,
   output logic             go_loopback
);

   logic [LANES-1:0] tx_q;
   logic [LANES-1:0] elig;
   logic             dis_cond;
   logic             lpb_cond;
   logic             dis_prev_q;
   logic             lpb_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
      end else begin
         tx_q <= tx_ts1;
      end
   end

   always_comb begin
      elig     = tx_q & rcv_ts1;
      dis_cond = |(tx_q & dis_hit);
      lpb_cond = (|elig) && ((lpb_hit & elig) == elig);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dis_prev_q <= 1'b0;
         lpb_prev_q <= 1'b0;
      end else if (clr) begin
         dis_prev_q <= 1'b0;
         lpb_prev_q <= 1'b0;
      end else begin
         dis_prev_q <= dis_cond;
         lpb_prev_q <= lpb_cond;
      end
   end

   assign go_disabled = dis_cond && !dis_prev_q;
   assign go_loopback = lpb_cond && !lpb_prev_q && !dis_cond;

endmodule

// File: rtl/ts1_ctl_detector.sv
module ts1_ctl_detector
   import ts1det_pkg::*;
#(
   parameter int unsigned LANES      = 4,
   parameter int unsigned NUM_W      = SYM_W,
   parameter int unsigned HIT_TARGET = 2,
   parameter bit          CHECK_IMPL = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   num_chk_en,
   input  logic                   lane_mode,
   input  logic [NUM_W-1:0]       exp_link,
   input  logic [LANES*NUM_W-1:0] exp_lane,
   input  logic [LANES-1:0]       tx_ts1,
   input  logic [LANES-1:0]       os_vld,
   input  logic [LANES-1:0]       os_is_ts1,
   input  logic [LANES*NUM_W-1:0] rx_link,
   input  logic [LANES*NUM_W-1:0] rx_lane,
   input  logic [LANES-1:0]       rx_dis_bit,
   input  logic [LANES-1:0]       rx_lpb_bit,
   output logic                   go_disabled,
   output logic                   go_loopback
);

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("ts1_ctl_detector: LANES must be at least 1");
      end
      if (NUM_W != SYM_W) begin : g_bad_width
         $error("ts1_ctl_detector: NUM_W must equal the symbol width");
      end
      if (HIT_TARGET < 1) begin : g_bad_target
         $error("ts1_ctl_detector: HIT_TARGET must be at least 1");
      end
   endgenerate

   lane_mode_e       mode_sel;
   logic [LANES-1:0] dis_hit;
   logic [LANES-1:0] lpb_hit;
   logic [LANES-1:0] rcv_ts1;

   assign mode_sel = lane_mode_e'(lane_mode);

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         ts1det_lane #(
            .NUM_W      (NUM_W),
            .TARGET     (HIT_TARGET),
            .CHECK_IMPL (CHECK_IMPL)
         ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .chk_en    (num_chk_en),
            .mode      (mode_sel),
            .exp_link  (exp_link),
            .exp_lane  (exp_lane[i*NUM_W +: NUM_W]),
            .os_vld    (os_vld[i]),
            .os_is_ts1 (os_is_ts1[i]),
            .rx_link   (rx_link[i*NUM_W +: NUM_W]),
            .rx_lane   (rx_lane[i*NUM_W +: NUM_W]),
            .rx_dis    (rx_dis_bit[i]),
            .rx_lpb    (rx_lpb_bit[i]),
            .dis_hit   (dis_hit[i]),
            .lpb_hit   (lpb_hit[i]),
            .rcv_ts1   (rcv_ts1[i])
         );
      end
   endgenerate

   ts1det_decide #(.LANES(LANES)) u_decide (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (clr),
      .tx_ts1      (tx_ts1),
      .rcv_ts1     (rcv_ts1),
      .dis_hit     (dis_hit),
      .lpb_hit     (lpb_hit),
      .go_disabled (go_disabled),
      .go_loopback (go_loopback)
   );

endmodule

// File: rtl/ts1det_chk.sv
module ts1det_chk #(
   parameter int unsigned LANES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic [LANES-1:0] tx_ts1,
   input logic             go_disabled,
   input logic             go_loopback
);

   AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      !(go_disabled && go_loopback)); // R10

   AST_DIS_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      go_disabled |=> !go_disabled); // R9

   AST_LPB_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      go_loopback |=> !go_loopback); // R9

   AST_DIS_NEEDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
      go_disabled |-> (|$past(tx_ts1))); // R2

   AST_LPB_NEEDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
      go_loopback |-> (|$past(tx_ts1))); // R4

   AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!go_disabled && !go_loopback)); // R11

endmodule

bind ts1_ctl_detector ts1det_chk #(.LANES(LANES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .clr         (clr),
   .tx_ts1      (tx_ts1),
   .go_disabled (go_disabled),
   .go_loopback (go_loopback)
);

// File: tb/ts1_ctl_detector_tb.sv
module ts1_ctl_detector_tb;

   localparam int unsigned LANES  = 4;
   localparam int unsigned NUM_W  = 8;
   localparam time         PERIOD = 10ns;
   localparam logic [7:0]  LINK_OK  = 8'h2A;
   localparam logic [7:0]  LINK_BAD = 8'h55;
   localparam logic [7:0]  LANE_BAD = 8'h33;
   localparam logic [7:0]  PAD      = 8'hF7;

   typedef struct packed {
      logic [3:0] req;
      logic [3:0] tx;
      logic [3:0] vld;
      logic [3:0] ts1;
      logic [3:0] dis;
      logic [3:0] lpb;
      logic       chk;
      logic       mode;
      logic       lok;
      logic [1:0] lsel;
      logic       edis;
      logic       elpb;
   } row_t;

   localparam int NROWS = 42;
   localparam row_t TBL [NROWS] = '{
      '{4'd1,  4'b1111, 4'b0001, 4'b0001, 4'b0001, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0}, // R1 first
      '{4'd1,  4'b1111, 4'b0001, 4'b0001, 4'b0001, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0}, // R1 second fires
      '{4'd9,  4'b1111, 4'b0001, 4'b0001, 4'b0001, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0}, // R9 no repeat
      '{4'd8,  4'b1111, 4'b0001, 4'b0001, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0}, // R8 bit clear
      '{4'd8,  4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},
      '{4'd8,  4'b1111, 4'b0001, 4'b0001, 4'b0001, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},
      '{4'd8,  4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0}, // R8 idle holds
      '{4'd8,  4'b1111, 4'b0001, 4'b0001, 4'b0001, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0},
      '{4'd8,  4'b1111, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0}, // R8 non-TS1
      '{4'd8,  4'b1111, 4'b0001, 4'b0001, 4'b0001, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},
      '{4'd8,  4'b1111, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},
      '{4'd8,  4'b1111, 4'b0001, 4'b0001, 4'b0001, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},
      '{4'd8,  4'b1111, 4'b0001, 4'b0001, 4'b0001, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0},
      '{4'd2,  4'b1111, 4'b0001, 4'b0001, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},
      '{4'd2,  4'b1101, 4'b0010, 4'b0010, 4'b0010, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0}, // R2 lane1 silent tx
      '{4'd2,  4'b1101, 4'b0010, 4'b0010, 4'b0010, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0}, // R2 excluded
      '{4'd2,  4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0}, // R2 joins, fires
      '{4'd2,  4'b1111, 4'b0010, 4'b0010, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},
      '{4'd3,  4'b1111, 4'b0011, 4'b0011, 4'b0000, 4'b0011, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0}, // R3
      '{4'd3,  4'b1111, 4'b0001, 4'b0001, 4'b0000, 4'b0001, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0}, // R3 one lane done
      '{4'd3,  4'b1111, 4'b0010, 4'b0010, 4'b0000, 4'b0010, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1}, // R3 all done
      '{4'd9,  4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},
      '{4'd4,  4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0}, // R4 none tx
      '{4'd4,  4'b1111, 4'b0011, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0}, // R4 none rcv
      '{4'd4,  4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},
      '{4'd10, 4'b1111, 4'b0001, 4'b0001, 4'b0001, 4'b0001, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0}, // R10
      '{4'd10, 4'b1111, 4'b0001, 4'b0001, 4'b0001, 4'b0001, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0}, // R10 both true
      '{4'd10, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},
      '{4'd10, 4'b1111, 4'b0001, 4'b0001, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},
      '{4'd6,  4'b1111, 4'b0001, 4'b0001, 4'b0001, 4'b0000, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0}, // R6 bad link
      '{4'd6,  4'b1111, 4'b0001, 4'b0001, 4'b0001, 4'b0000, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
      '{4'd7,  4'b1111, 4'b0001, 4'b0001, 4'b0001, 4'b0000, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0}, // R7 PAD
      '{4'd7,  4'b1111, 4'b0001, 4'b0001, 4'b0001, 4'b0000, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0},
      '{4'd7,  4'b1111, 4'b0001, 4'b0001, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},
      '{4'd7,  4'b1111, 4'b0001, 4'b0001, 4'b0001, 4'b0000, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0}, // R7 PAD wrong phase
      '{4'd7,  4'b1111, 4'b0001, 4'b0001, 4'b0001, 4'b0000, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0},
      '{4'd7,  4'b1111, 4'b0001, 4'b0001, 4'b0001, 4'b0000, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0}, // R7 assigned
      '{4'd7,  4'b1111, 4'b0001, 4'b0001, 4'b0001, 4'b0000, 1'b1, 1'b1, 1'b1, 2'd1, 1'b1, 1'b0},
      '{4'd7,  4'b1111, 4'b0001, 4'b0001, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0},
      '{4'd5,  4'b1111, 4'b0001, 4'b0001, 4'b0001, 4'b0000, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0}, // R5 numbers ignored
      '{4'd5,  4'b1111, 4'b0001, 4'b0001, 4'b0001, 4'b0000, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0},
      '{4'd5,  4'b1111, 4'b0001, 4'b0001, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0}
   };

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   clr = 1'b0;
   logic                   num_chk_en = 1'b0;
   logic                   lane_mode = 1'b0;
   logic [NUM_W-1:0]       exp_link = LINK_OK;
   logic [LANES*NUM_W-1:0] exp_lane;
   logic [LANES-1:0]       tx_ts1 = '0;
   logic [LANES-1:0]       os_vld = '0;
   logic [LANES-1:0]       os_is_ts1 = '0;
   logic [LANES*NUM_W-1:0] rx_link = '0;
   logic [LANES*NUM_W-1:0] rx_lane = '0;
   logic [LANES-1:0]       rx_dis_bit = '0;
   logic [LANES-1:0]       rx_lpb_bit = '0;
   logic                   go_disabled;
   logic                   go_loopback;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   ts1_ctl_detector #(.LANES(LANES)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (clr),
      .num_chk_en  (num_chk_en),
      .lane_mode   (lane_mode),
      .exp_link    (exp_link),
      .exp_lane    (exp_lane),
      .tx_ts1      (tx_ts1),
      .os_vld      (os_vld),
      .os_is_ts1   (os_is_ts1),
      .rx_link     (rx_link),
      .rx_lane     (rx_lane),
      .rx_dis_bit  (rx_dis_bit),
      .rx_lpb_bit  (rx_lpb_bit),
      .go_disabled (go_disabled),
      .go_loopback (go_loopback)
   );

   initial begin
      for (int i = 0; i < LANES; i++) exp_lane[i*NUM_W +: NUM_W] = 8'h10 + 8'(i);
   end

   task automatic check(input string req, input logic edis, input logic elpb);
      n_checks++;
      if (go_disabled !== edis || go_loopback !== elpb) begin
         n_fail++;
         $display("FAIL %s: go_disabled/go_loopback = %b/%b, expected %b/%b",
                  req, go_disabled, go_loopback, edis, elpb);
      end
   endtask

   task automatic drive(input row_t r);
      tx_ts1     = r.tx;
      os_vld     = r.vld;
      os_is_ts1  = r.ts1;
      rx_dis_bit = r.dis;
      rx_lpb_bit = r.lpb;
      num_chk_en = r.chk;
      lane_mode  = r.mode;
      for (int i = 0; i < LANES; i++) begin
         rx_link[i*NUM_W +: NUM_W] = r.lok ? LINK_OK : LINK_BAD;
         case (r.lsel)
            2'd0:    rx_lane[i*NUM_W +: NUM_W] = PAD;
            2'd1:    rx_lane[i*NUM_W +: NUM_W] = exp_lane[i*NUM_W +: NUM_W];
            default: rx_lane[i*NUM_W +: NUM_W] = LANE_BAD;
         endcase
      end
   endtask

   function automatic row_t mk(input logic [3:0] vld, input logic [3:0] ts1,
                               input logic [3:0] dis);
      row_t r;
      r = '0;
      r.tx = 4'b1111; r.vld = vld; r.ts1 = ts1; r.dis = dis; r.lok = 1'b1;
      return r;
   endfunction

   initial begin
      drive(mk(4'b0000, 4'b0000, 4'b0000));
      repeat (3) @(negedge clk);
      check("R12 in reset", 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 after reset", 1'b0, 1'b0);

      for (int k = 0; k < NROWS; k++) begin
         drive(TBL[k]);
         @(negedge clk);
         check($sformatf("R%0d row %0d", TBL[k].req, k), TBL[k].edis, TBL[k].elpb);
      end

      // R11: a streak started before clr does not survive it
      drive(mk(4'b0001, 4'b0001, 4'b0001));
      @(negedge clk);
      check("R11 pre-clear", 1'b0, 1'b0);
      drive(mk(4'b0000, 4'b0000, 4'b0000));
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      check("R11 clear cycle", 1'b0, 1'b0);
      drive(mk(4'b0001, 4'b0001, 4'b0001));
      @(negedge clk);
      check("R11 restart one", 1'b0, 1'b0);
      @(negedge clk);
      check("R11 restart two", 1'b1, 1'b0);

      // R12: reset in the middle wipes the streak
      drive(mk(4'b0001, 4'b0001, 4'b0000));
      @(negedge clk);
      drive(mk(4'b0001, 4'b0001, 4'b0001));
      @(negedge clk);
      rst_n = 1'b0;
      drive(mk(4'b0000, 4'b0000, 4'b0000));
      @(negedge clk);
      check("R12 mid reset", 1'b0, 1'b0);
      rst_n = 1'b1;
      drive(mk(4'b0001, 4'b0001, 4'b0001));
      @(negedge clk);
      check("R12 streak restarted", 1'b0, 1'b0);

      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(PERIOD * 20000);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual hung, expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule